// File: doc/BRIEF.md
# MII Receive Nibble-to-Byte Framer

This block sits behind an external Ethernet PHY on the media-independent receive path. On every enabled rising edge of the receive clock it samples a 4-bit data nibble, a data-valid flag, a receive-error flag and carrier sense. It packs nibble pairs into bytes and hands them on as a byte stream. Each byte comes with a one-cycle valid strobe, and the first and last bytes of every frame carry marker bits. The last byte also carries the frame's error status.

The PHY may stall its clock at the edges of a frame. Here that is modelled as a clock-enable input that drops for a few cycles. The framer ignores every edge where the enable is low, and it never reads a frame boundary out of such a gap. A frame is taken only if carrier sense has been seen low since the previous accepted frame, or since reset. A frame that arrives without that gap is discarded whole. A receive-error flag raised while data-valid is low is an out-of-band condition. It is discarded and has no effect.

Top module: `mii_rx_framer`

## Requirements
- R1: Inputs are sampled only on rising edges where `rxClkEn` is 1. Edges with `rxClkEn` at 0 change nothing and produce no output byte, whatever the other inputs carry.
- R2: Nibbles are packed low nibble first. Byte k of a frame is {nibble 2k+1, nibble 2k}, with bit 0 of the first nibble landing on `byteData[0]`.
- R3: A frame starts on the first enabled edge with `rxDv` 1 and ends on the first later enabled edge with `rxDv` 0. The last byte is presented with `byteLast` 1 in the clock cycle that follows that ending edge. A frame of n nibbles (n ≥ 2) yields floor(n/2) bytes.
- R4: `byteFirst` is 1 on the first byte of every frame and 0 on every other byte.
- R5: If `rxErr` is 1 on any enabled edge where the frame's `rxDv` is 1, `byteErr` is 1 on that frame's last byte. `byteErr` is 0 on every other byte and on frames with no such edge.
- R6: `rxErr` sampled while `rxDv` is 0 outside a frame produces no output and does not set the error status of the next frame.
- R7: A frame is accepted only if `rxCrs` was sampled 0 on an enabled edge after the previous accepted frame began, or after reset. Otherwise the whole frame produces no output bytes.
- R8: A frame with an odd nibble count has `byteAlign` 1 on its last byte, and its trailing unpaired nibble is dropped. A one-nibble frame yields a single byte {4'h0, nibble 0} with `byteFirst`, `byteLast` and `byteAlign` all 1.
- R9: While reset is asserted and until the first byte is produced, `byteValid`, `byteData`, `byteFirst`, `byteLast`, `byteErr` and `byteAlign` are all 0.
- R10: `byteValid` stays high for exactly one clock cycle per byte. `byteErr` and `byteAlign` are 1 only together with `byteLast`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock (rising edge) |
| rstN | input | 1 | Asynchronous active-low reset |
| rxClkEn | input | 1 | Qualifies the current edge; 0 models a stalled PHY clock |
| rxNib | input | 4 | Receive data nibble |
| rxDv | input | 1 | Receive data valid |
| rxErr | input | 1 | Receive error from the PHY |
| rxCrs | input | 1 | Carrier sense |
| byteValid | output | 1 | One-cycle strobe for an output byte |
| byteData | output | 8 | Assembled byte |
| byteFirst | output | 1 | Byte is the first of its frame |
| byteLast | output | 1 | Byte is the last of its frame |
| byteErr | output | 1 | Frame carried an in-frame receive error (with byteLast) |
| byteAlign | output | 1 | Frame had an odd nibble count (with byteLast) |

## Verification
The assertions take for granted that `rxDv` holds steady across disabled edges and that the PHY never raises carrier sense and data-valid in a way that needs a clock edge the enable masks. They check only how enabled edges relate to the byte outputs. The stimulus changes inputs once per cycle, away from the active edge. It holds `rxDv` constant through every injected clock-enable gap, while the data nibble and the error flag toggle freely during those gaps. This checks that masked edges are ignored without ever showing the framer a masked frame boundary. Carrier sense is dropped only between frames, except in the cases that check frame rejection, where it is deliberately left high.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECV   = 2'd1,
    ST_REJECT = 2'd2
  } rxState_e;

  // strobes from control to datapath, each valid for one enabled edge
  typedef struct packed {
    logic startFrame;
    logic takeNib;
    logic endFrame;
    logic markErr;
  } rxCtl_t;
endpackage

// File: rtl/mii_rx_ctrl.sv
module mii_rx_ctrl
  import mii_rx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxClkEn,
  input  logic   rxDv,
  input  logic   rxErr,
  input  logic   rxCrs,
  output rxCtl_t ctl
);
  rxState_e state, stateNext;
  logic     armed, armedNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    armedNext = armed;
    if (rxClkEn) begin
      if (!rxCrs) armedNext = 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (rxDv) begin
            if (armed) begin
              ctl.startFrame = 1'b1;
              ctl.takeNib    = 1'b1;
              ctl.markErr    = rxErr;
              armedNext      = 1'b0;
              stateNext      = ST_RECV;
            end else begin
              stateNext = ST_REJECT;
            end
          end
        end
        ST_RECV: begin
          if (rxDv) begin
            ctl.takeNib = 1'b1;
            ctl.markErr = rxErr;
          end else begin
            ctl.endFrame = 1'b1;
            stateNext    = ST_IDLE;
          end
        end
        ST_REJECT: begin
          if (!rxDv) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      state <= stateNext;
      armed <= armedNext;
    end
  end

  // R1
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxClkEn |=> ($stable(state) && $stable(armed)));

  // R7
  reject_nostart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REJECT) |-> !ctl.startFrame);
endmodule

// File: rtl/mii_rx_dpath.sv
module mii_rx_dpath
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxCtl_t            ctl,
  input  logic [NIB_W-1:0]  rxNib,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteFirst,
  output logic              byteLast,
  output logic              byteErr,
  output logic              byteAlign
);
  logic [NIB_W-1:0]  loNib;
  logic              haveLo;
  logic [BYTE_W-1:0] pendByte;
  logic              pendValid;
  logic              pendFirst;
  logic              errLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loNib     <= '0;
      haveLo    <= 1'b0;
      pendByte  <= '0;
      pendValid <= 1'b0;
      pendFirst <= 1'b0;
      errLat    <= 1'b0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteFirst <= 1'b0;
      byteLast  <= 1'b0;
      byteErr   <= 1'b0;
      byteAlign <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      byteFirst <= 1'b0;
      byteLast  <= 1'b0;
      byteErr   <= 1'b0;
      byteAlign <= 1'b0;
      if (ctl.startFrame) begin
        loNib     <= rxNib;
        haveLo    <= 1'b1;
        pendValid <= 1'b0;
        pendFirst <= 1'b1;
        errLat    <= ctl.markErr;
      end else if (ctl.takeNib) begin
        errLat <= errLat | ctl.markErr;
        if (!haveLo) begin
          loNib  <= rxNib;
          haveLo <= 1'b1;
        end else begin
          haveLo    <= 1'b0;
          pendByte  <= {rxNib, loNib};
          pendValid <= 1'b1;
          if (pendValid) begin
            byteValid <= 1'b1;
            byteData  <= pendByte;
            byteFirst <= pendFirst;
            pendFirst <= 1'b0;
          end
        end
      end else if (ctl.endFrame) begin
        byteValid <= 1'b1;
        byteLast  <= 1'b1;
        byteFirst <= pendFirst;
        byteErr   <= errLat;
        byteAlign <= haveLo;
        byteData  <= pendValid ? pendByte : {{NIB_W{1'b0}}, loNib};
        pendValid <= 1'b0;
        haveLo    <= 1'b0;
        errLat    <= 1'b0;
      end
    end
  end

  // R3
  end_emits_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.endFrame |=> (byteValid && byteLast));

  // R1
  idle_no_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl == '0) |=> !byteValid);

  // R8
  lone_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.endFrame && !pendValid) |=> (byteFirst && byteAlign));

  // R10
  status_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteErr || byteAlign) |-> (byteLast && byteValid));

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteLast) |=> !(byteValid && byteLast));
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxClkEn,
  input  logic [3:0]  rxNib,
  input  logic        rxDv,
  input  logic        rxErr,
  input  logic        rxCrs,
  output logic        byteValid,
  output logic [7:0]  byteData,
  output logic        byteFirst,
  output logic        byteLast,
  output logic        byteErr,
  output logic        byteAlign
);
  rxCtl_t ctl;

  mii_rx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxClkEn (rxClkEn),
    .rxDv    (rxDv),
    .rxErr   (rxErr),
    .rxCrs   (rxCrs),
    .ctl     (ctl)
  );

  mii_rx_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .rxNib     (rxNib),
    .byteValid (byteValid),
    .byteData  (byteData),
    .byteFirst (byteFirst),
    .byteLast  (byteLast),
    .byteErr   (byteErr),
    .byteAlign (byteAlign)
  );
endmodule

// File: tb/tb_mii_rx_framer.sv
module tb_mii_rx_framer;
  logic       clk = 1'b0;
  logic       rstN;
  logic       rxClkEn;
  logic [3:0] rxNib;
  logic       rxDv;
  logic       rxErr;
  logic       rxCrs;
  logic       byteValid;
  logic [7:0] byteData;
  logic       byteFirst;
  logic       byteLast;
  logic       byteErr;
  logic       byteAlign;

  always #5 clk = ~clk;

  mii_rx_framer dut (
    .clk(clk), .rstN(rstN), .rxClkEn(rxClkEn), .rxNib(rxNib), .rxDv(rxDv),
    .rxErr(rxErr), .rxCrs(rxCrs), .byteValid(byteValid), .byteData(byteData),
    .byteFirst(byteFirst), .byteLast(byteLast), .byteErr(byteErr),
    .byteAlign(byteAlign)
  );

  int nChecks = 0;
  int nFail   = 0;

  logic [7:0] capData  [256];
  logic [3:0] capFlags [256];
  int         capCount = 0;

  always @(negedge clk) begin
    if (rstN === 1'b1 && byteValid === 1'b1 && capCount < 256) begin
      capData[capCount]  = byteData;
      capFlags[capCount] = {byteFirst, byteLast, byteErr, byteAlign};
      capCount = capCount + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [3:0] n, input logic dv,
                       input logic er, input logic cs);
    @(negedge clk);
    rxClkEn = en; rxNib = n; rxDv = dv; rxErr = er; rxCrs = cs;
  endtask

  // fields: [17:12] nibbles, [11:8] seed, [7:2] error position (63 none),
  // [1] carrier drop before frame, [0] clock-enable gaps inside frame
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {6'd8,  4'h1, 6'd63, 1'b1, 1'b0},
    {6'd9,  4'h5, 6'd63, 1'b1, 1'b1},
    {6'd6,  4'hA, 6'd3,  1'b1, 1'b1},
    {6'd2,  4'h3, 6'd0,  1'b1, 1'b0},
    {6'd10, 4'h7, 6'd63, 1'b0, 1'b0},
    {6'd4,  4'hC, 6'd63, 1'b1, 1'b1},
    {6'd1,  4'h9, 6'd63, 1'b1, 1'b0},
    {6'd12, 4'h0, 6'd11, 1'b1, 1'b0}
  };

  task automatic sendFrame(input int n, input logic [3:0] seed, input int errPos,
                           input logic drop, input logic gaps);
    if (drop) begin
      drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b0);
      drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b0);
    end
    drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < n; i++) begin
      logic [3:0] nib;
      nib = seed + 4'(i);
      if (gaps && i == 0) begin
        drive(1'b0, 4'hF, 1'b1, 1'b1, 1'b1);
        drive(1'b0, 4'h6, 1'b1, 1'b0, 1'b1);
      end
      drive(1'b1, nib, 1'b1, (i == errPos), 1'b1);
      if (gaps && i == n / 2) begin
        drive(1'b0, ~nib, 1'b1, 1'b1, 1'b1);
        drive(1'b0, 4'h5, 1'b1, 1'b1, 1'b1);
      end
    end
    if (gaps) begin
      drive(1'b0, 4'hE, 1'b0, 1'b1, 1'b1);
      drive(1'b0, 4'h1, 1'b0, 1'b0, 1'b1);
    end
    drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic runFrame(input int n, input logic [3:0] seed, input int errPos,
                          input logic drop, input logic gaps, input logic accepted);
    int base;
    int expCnt;
    #1;
    base = capCount;
    sendFrame(n, seed, errPos, drop, gaps);
    #1;
    expCnt = !accepted ? 0 : (n == 1 ? 1 : n / 2);
    if (!accepted) check("R7 rejected frame byte count", capCount - base, 0);
    else if (gaps) check("R1 R3 byte count with clock gaps", capCount - base, expCnt);
    else check("R3 byte count", capCount - base, expCnt);
    for (int k = 0; k < expCnt && base + k < 256; k++) begin
      logic [3:0] lo, hi;
      logic [7:0] expData;
      logic       isLast;
      lo = seed + 4'(2 * k);
      hi = seed + 4'(2 * k + 1);
      expData = (n == 1) ? {4'h0, lo} : {hi, lo};
      isLast = (k == expCnt - 1);
      check("R2 R8 byte data", int'(capData[base + k]), int'(expData));
      check("R4 R3 R5 R8 R10 byte flags", int'(capFlags[base + k]),
            int'({k == 0, isLast, isLast && (errPos < n), isLast && (n % 2 == 1)}));
    end
  endtask

  logic wdExpired = 1'b0;

  initial begin
    rstN = 1'b0; rxClkEn = 1'b1; rxNib = 4'h0; rxDv = 1'b0; rxErr = 1'b0; rxCrs = 1'b1;
    fork
      begin
        repeat (3) @(negedge clk);
        check("R9 outputs in reset",
              int'({byteValid, byteData, byteFirst, byteLast, byteErr, byteAlign}), 0);
        rstN = 1'b1;
        drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
        drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
        check("R9 outputs after reset",
              int'({byteValid, byteData, byteFirst, byteLast, byteErr, byteAlign}), 0);

        // R7: no carrier drop since reset, frame must be discarded
        runFrame(4, 4'h2, 63, 1'b0, 1'b0, 1'b0);

        // R6: out-of-band error pulses with data-valid low
        begin
          int base;
          drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b0);
          #1; base = capCount;
          for (int i = 0; i < 3; i++) drive(1'b1, 4'(i), 1'b0, 1'b1, 1'b1);
          drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
          drive(1'b1, 4'h0, 1'b0, 1'b0, 1'b1);
          #1;
          check("R6 out-of-band error gives no output", capCount - base, 0);
        end
        // R6: next frame carries no error status
        runFrame(4, 4'h4, 63, 1'b0, 1'b0, 1'b1);

        for (int v = 0; v < NV; v++) begin
          logic [17:0] e;
          e = VEC[v];
          runFrame(int'(e[17:12]), e[11:8], int'(e[7:2]), e[1], e[0], e[1]);
        end
      end
      begin
        repeat (20000) @(posedge clk);
        wdExpired = 1'b1;
      end
    join_any
    disable fork;
    if (wdExpired) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual expired expected finished");
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule